// File: doc/BRIEF.md
# Sixteen-Bit Tick Counter with Coherent Byte Read

This block is a free-running up-counter, sixteen bits wide by default, that an eight-bit register bus reaches as two separate byte locations plus one control location. The counter moves forward by one on each cycle in which a one-cycle tick pulse from an external timebase selector is present and counting is permitted. Counting is permitted when the run bit is set, and it is also held off while the processor is idle if the idle-hold bit is set.

Software reads a consistent sixteen-bit value by reading the low byte first. That read copies the high byte into a shadow register. The next high-byte read returns the shadow copy, even if the counter has carried into the high byte in the meantime. When the count rolls over from all ones to zero, a sticky overflow flag is raised. An interrupt request follows that flag only while the interrupt-enable bit is set. Hardware never clears the flag. Software clears it by writing 0 to the flag bit.

Top module: `snapcnt_top`

## Requirements
- R1: After reset the count, the shadow register, every control bit, the overflow flag and the interrupt request are all 0.
- R2: The count increases by exactly one on each rising edge where `tick` is 1 and the run bit (control bit 0) is 1, unless that edge is frozen by R3 or overridden by a byte write. Otherwise the count does not change.
- R3: While `cpu_idle` is 1, the count keeps advancing if the idle-hold bit (control bit 2) is 0. It does not advance if the idle-hold bit is 1.
- R4: A read pulse on address 0 returns the live low byte and copies the live high byte into the shadow register. A read on address 1 returns the shadow register. Read data appears on `bus_rdata` one cycle after the read pulse.
- R5: Reads of any address never change the count and never stall it. A read in a cycle with a tick returns the value from before that increment.
- R6: When an increment takes the count from all ones to zero, the overflow flag (control bit 7) becomes 1 on that same edge.
- R7: `irq` is 1 exactly when both the overflow flag and the interrupt-enable bit (control bit 1) are 1.
- R8: Only a write to address 2 with bit 7 equal to 0 clears the overflow flag. Writing 1 to bit 7 leaves the flag unchanged. If a wrap and a clearing write fall on the same edge, the flag ends at 1.
- R9: A write to address 0 loads the low byte and a write to address 1 loads the high byte. The other byte is unchanged, and no increment takes place on the edge of the write.
- R10: A high-byte read that has no earlier low-byte read returns the most recent shadow value: 0 after reset, otherwise the value captured by the last low-byte read.
- R11: A read of address 2 returns run, interrupt-enable, idle-hold and flag in bits 0, 1, 2 and 7, with all other bits 0. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle advance pulse from the timebase selector |
| cpu_idle | input | 1 | Processor idle indication |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 unused |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a counter increment and a bus access. The second pair is a rollover and a software clear of the flag. The bench drives both in the same cycle: a tick together with a low-byte read, a tick together with a byte write, and a tick at count all-ones together with a control write that clears the flag. It then judges the result from the read data, the next full count read, the control byte and `irq`. The expected outcomes are the pre-increment value for the read, the written byte with no increment for the write, and a flag that stays set for the clear.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LO  = 2'd0,
    SEL_HI  = 2'd1,
    SEL_CTL = 2'd2,
    SEL_RSV = 2'd3
  } sel_e;

  localparam int CB_RUN  = 0;
  localparam int CB_IE   = 1;
  localparam int CB_HOLD = 2;
  localparam int CB_FLAG = 7;
endpackage

// File: rtl/snapcnt_core.sv
module snapcnt_core #(
  parameter int DW = 8,
  parameter int NB = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [NB-1:0]      wr_lane,
  input  logic [DW-1:0]      wdata,
  output logic [NB*DW-1:0]   cnt,
  output logic               wrap
);
  localparam int CW = NB * DW;

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          any_wr;

  assign any_wr  = |wr_lane;
  assign cnt_inc = cnt_q + {{(CW-1){1'b0}}, 1'b1};

  always_comb begin
    cnt_d = (adv && !any_wr) ? cnt_inc : cnt_q;
  end

  logic [CW-1:0] cnt_n;
  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_lane
      assign cnt_n[g*DW +: DW] = wr_lane[g] ? wdata : cnt_d[g*DW +: DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign cnt  = cnt_q;
  assign wrap = adv && !any_wr && (&cnt_q);

  AST_INC_ONE: assert property (@(posedge clk) disable iff (rst)
    (adv && !any_wr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!adv && !any_wr) |=> $stable(cnt_q)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0)); // R6
  AST_LANE_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_lane[0] |=> (cnt_q[DW-1:0] == $past(wdata))); // R9
endmodule

// File: rtl/snapcnt_shadow.sv
module snapcnt_shadow #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] hi_in,
  output logic [DW-1:0] snap
);
  logic [DW-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (capture) snap_q <= hi_in;
  end

  assign snap = snap_q;

  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
    capture |=> (snap_q == $past(hi_in))); // R4
  AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(snap_q)); // R10
endmodule

// File: rtl/snapcnt_ctl.sv
module snapcnt_ctl
  import snapcnt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  input  logic          wrap,
  output logic          run,
  output logic          ie,
  output logic          hold,
  output logic          flag,
  output logic          irq
);
  logic run_q, ie_q, hold_q, flag_q, irq_q;
  logic run_n, ie_n, hold_n, flag_n;
  logic sw_clr;

  assign sw_clr = wr_ctl && !wdata[CB_FLAG];

  always_comb begin
    run_n  = wr_ctl ? wdata[CB_RUN]  : run_q;
    ie_n   = wr_ctl ? wdata[CB_IE]   : ie_q;
    hold_n = wr_ctl ? wdata[CB_HOLD] : hold_q;
    flag_n = wrap || (flag_q && !sw_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      hold_q <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_n;
      ie_q   <= ie_n;
      hold_q <= hold_n;
      flag_q <= flag_n;
      irq_q  <= flag_n && ie_n;
    end
  end

  assign run  = run_q;
  assign ie   = ie_q;
  assign hold = hold_q;
  assign flag = flag_q;
  assign irq  = irq_q;

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && ie_q)); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ie_q) |-> irq_q); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_ctl) |=> flag_q); // R8
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top
  import snapcnt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cpu_idle,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam int NB = 2;
  localparam int CW = NB * DW;

  logic [CW-1:0] cnt;
  logic [DW-1:0] snap;
  logic          wrap, adv, run, ie, hold, flag;
  logic [NB-1:0] wr_lane;
  logic          wr_ctl, cap;
  logic [DW-1:0] rd_mux, rdata_q, ctl_byte;

  assign wr_lane[0] = bus_wr && (bus_addr == SEL_LO);
  assign wr_lane[1] = bus_wr && (bus_addr == SEL_HI);
  assign wr_ctl     = bus_wr && (bus_addr == SEL_CTL);
  assign cap        = bus_rd && (bus_addr == SEL_LO);
  assign adv        = tick && run && !(hold && cpu_idle);

  snapcnt_core #(.DW(DW), .NB(NB)) u_core (
    .clk(clk), .rst(rst), .adv(adv), .wr_lane(wr_lane),
    .wdata(bus_wdata), .cnt(cnt), .wrap(wrap)
  );

  snapcnt_shadow #(.DW(DW)) u_shadow (
    .clk(clk), .rst(rst), .capture(cap),
    .hi_in(cnt[CW-1 -: DW]), .snap(snap)
  );

  snapcnt_ctl #(.DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wdata(bus_wdata),
    .wrap(wrap), .run(run), .ie(ie), .hold(hold), .flag(flag), .irq(irq)
  );

  always_comb begin
    ctl_byte          = '0;
    ctl_byte[CB_RUN]  = run;
    ctl_byte[CB_IE]   = ie;
    ctl_byte[CB_HOLD] = hold;
    ctl_byte[CB_FLAG] = flag;
    unique case (bus_addr)
      SEL_LO:  rd_mux = cnt[DW-1:0];
      SEL_HI:  rd_mux = snap;
      SEL_CTL: rd_mux = ctl_byte;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (cpu_idle && hold && !bus_wr) |=> $stable(cnt)); // R3
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !tick) |=> $stable(cnt)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata_q)); // R4
endmodule

// File: tb/tb_snapcnt_top.sv
module tb_snapcnt_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cpu_idle = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  snapcnt_top dut (
    .clk(clk), .rst(rst), .tick(tick), .cpu_idle(cpu_idle),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic set16(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    int exp;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 / R10: reset state, high read before any low read gives 0
    rd(2'd2, b); check("R1 ctrl", b, 0);
    check("R1 irq", irq, 0);
    rd(2'd1, b); check("R10 shadow after reset", b, 0);
    rd(2'd0, b); check("R1 low", b, 0);
    rd(2'd3, b); check("R11 unused addr", b, 0);

    // R2: no advance with run=0
    ticks(5);
    rd16(v); check("R2 run off", v, 0);

    // R2: sweep of tick bursts with run=1
    wr(2'd2, 8'h01);
    rd(2'd2, b); check("R11 ctrl readback", b, 8'h01);
    exp = 0;
    for (int n = 0; n <= 30; n++) begin
      ticks(n);
      exp += n;
      rd16(v); check("R2 burst count", v, exp);
    end

    // R3: idle with hold=0 keeps counting; hold=1 freezes
    cpu_idle = 1'b1;
    ticks(10); exp += 10;
    rd16(v); check("R3 idle no hold", v, exp);
    wr(2'd2, 8'h05);
    ticks(10);
    rd16(v); check("R3 idle hold freeze", v, exp);
    cpu_idle = 1'b0;
    ticks(3); exp += 3;
    rd16(v); check("R3 hold not idle", v, exp);
    wr(2'd2, 8'h01);

    // R5: many reads leave count unchanged
    for (int i = 0; i < 20; i++) rd(2'(i % 4), b);
    rd16(v); check("R5 reads no disturb", v, exp);

    // R5: read low in the same cycle as a tick returns pre-increment value
    set16(16'h40FF);
    @(negedge clk);
    tick = 1'b1; bus_addr = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_rd = 1'b0;
    check("R5 read with tick", bus_rdata, 8'hFF);
    rd(2'd1, b); check("R4 shadow pre-carry", b, 8'h40);
    rd16(v); check("R5 count after read+tick", v, 16'h4100);

    // R9: byte write sweep
    for (int i = 0; i < 256; i++) begin
      set16({8'(i) ^ 8'hA5, 8'(i)});
      rd16(v); check("R9 byte load", v, {8'(i) ^ 8'hA5, 8'(i)});
    end

    // R9: write with tick -> no increment, other byte kept
    set16(16'h2233);
    @(negedge clk);
    tick = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h10; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd16(v); check("R9 write beats tick", v, 16'h2210);

    // R4 / R10: coherent snapshot across carry
    set16(16'h12FF);
    rd(2'd0, b); check("R4 low read", b, 8'hFF);
    ticks(1);
    rd(2'd1, b); check("R4 high from shadow", b, 8'h12);
    rd(2'd0, b); check("R4 low after carry", b, 8'h00);
    rd(2'd1, b); check("R4 high after carry", b, 8'h13);
    ticks(256);
    rd(2'd1, b); check("R10 stale shadow kept", b, 8'h13);
    rd16(v); check("R2 after 256 ticks", v, 16'h1400);

    // R6 / R7: wrap sets flag, irq gated by enable
    set16(16'hFFFE);
    ticks(2);
    rd(2'd2, b); check("R6 flag set on wrap", b, 8'h81);
    check("R7 irq off when disabled", irq, 0);
    rd16(v); check("R6 count wrapped", v, 0);
    wr(2'd2, 8'h83);
    rd(2'd2, b); check("R8 write 1 keeps flag", b, 8'h83);
    check("R7 irq on", irq, 1);
    wr(2'd2, 8'h03);
    rd(2'd2, b); check("R8 write 0 clears flag", b, 8'h03);
    check("R7 irq off after clear", irq, 0);
    wr(2'd2, 8'h83);
    rd(2'd2, b); check("R8 write 1 no set", b, 8'h03);
    ticks(100);
    rd(2'd2, b); check("R8 flag stays clear", b, 8'h03);

    // R8: wrap and clearing write on the same edge -> set wins
    set16(16'hFFFF);
    @(negedge clk);
    tick = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h03; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(2'd2, b); check("R8 set beats clear", b, 8'h83);
    check("R7 irq with set-wins", irq, 1);
    rd16(v); check("R6 wrap with ctl write", v, 0);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", irq, 0);
    rd(2'd2, b); check("R1 ctrl after reset", b, 0);
    rd(2'd1, b); check("R1 shadow after reset", b, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule